// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into a PCI-side address, a PCI cycle type and a prefetch hint. It holds three programmable windows. Each window has a base register and a map register, and software loads them through a plain write port. For every translation request the block tests the address against every enabled window. The window with the lowest index whose range contains the address supplies the result. One clock later the block reports either a hit, with the translated address, or a one-cycle miss.

Windows 0 and 1 have a size from 1 MB up to 2 GB, and each carries its own cycle type: memory, memory-multiple, configuration, I/O or interrupt acknowledge. Window 2 is a fixed 16 MB I/O window. Because the lowest index wins, software can grow window 0 so that it covers window 1, reprogram window 1 while it is hidden, and then shrink window 0 again.

A small controller keeps the response state:

- **ST_IDLE**: no request was presented in the previous cycle.
- **ST_HIT**: a request matched a window.
- **ST_MISS**: a request matched no window.

From every state the next state is chosen the same way:

- **idle transition**: taken when `req_valid` is low; the next state is ST_IDLE.
- **hit transition**: taken when `req_valid` is high and some window matches; the next state is ST_HIT.
- **miss transition**: taken when `req_valid` is high and no window matches; the next state is ST_MISS.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset every register field is zero and every window is disabled, so every request misses.
- R2: `cfg_sel` chooses the register to write. Bit 0 selects base (0) or map (1), and bits 2:1 give the window index. The values 6 and 7 select nothing, and a write to them changes no translation. A write done in one cycle already applies to a request presented in the next cycle.
- R3: For windows 0 and 1 the base register is laid out as follows: bit 0 enables the window, bit 3 is the prefetch flag, bits 7:4 are the size code, and bits 31:20 are the local base. A size code s from 0 to 11 gives a window of 2^(20+s) bytes. A window with a size code from 12 to 15 never hits.
- R4: On a hit in window 0 or 1, the address bits at and above log2(size) come from the map address, which is map bits 15:4 placed at PCI address bits 31:20. The bits below log2(size) come from the local address.
- R5: Map bit 0 of windows 0 and 1 is the low-address enable. When it is 0, PCI address bits 1:0 are 0. When it is 1, they are copied from the local address.
- R6: The cycle type reported for windows 0 and 1 is map bits 3:1, passed through without change (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple). The prefetch output is base bit 3.
- R7: Window 2 always covers 16 MB. Its base bits 15:8 are local address bits 31:24 and its base bit 0 is the enable. Map bits 15:8 become PCI address bits 31:24, and local bits 23:0 pass through unchanged. The cycle type is 001 and prefetch is 0. Its base bits 7:6 have no effect on the translation.
- R8: When windows overlap, the lowest-indexed enabled matching window wins, and `rsp_win` reports its index.
- R9: A request that matches no window gives `rsp_miss` high for exactly one cycle, with `rsp_hit` low and address, cycle type, prefetch and window index all zero.
- R10: The response comes one clock after the request. A cycle with no request gives neither hit nor miss in the next cycle.
- R11: For windows 0 and 1, base bits below log2(size) are ignored when the address is compared.
- R12: A window whose enable bit is 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (R2 encoding) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Local-bus address |
| rsp_hit | output | 1 | Request hit a window (one cycle later) |
| rsp_miss | output | 1 | Request hit no window (one cycle later) |
| rsp_win | output | 2 | Index of the winning window |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_cycle | output | 3 | PCI cycle type |
| rsp_prefetch | output | 1 | Prefetch hint |

## Verification
The assertions assume that `req_valid` and `req_addr` are stable across each rising edge. They also assume that `cfg_we` is never high in the same cycle as a request whose result depends on the register being written, because such a request is translated with the old register values. The bench keeps within both assumptions. It drives all inputs on the falling edge, and it issues every write one cycle before any request that relies on it. The stimulus sweeps all sixteen size codes and all eight cycle-type codes. It probes each window at its edges and just outside them, and it stacks windows on top of one another so that every pairing used in the priority tests is exercised.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int NUM_WIN      = 3;
    localparam int ADDR_W       = 32;
    localparam int MAP_W        = 16;
    localparam int MIN_LOG2     = 20;
    localparam int IO_LOG2      = 24;
    localparam int MAX_CODE     = 11;
    localparam int WIN_IDX_W    = $clog2(NUM_WIN);
    localparam logic [2:0] CYC_IO = 3'b001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        cyc;
        logic              pf;
    } win_result_t;
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
    import xlat_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [2:0]                         sel,
    input  logic [ADDR_W-1:0]                  wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]     base_o,
    output logic [NUM_WIN-1:0][MAP_W-1:0]      map_o
);
    localparam int IO_IDX = NUM_WIN - 1;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_reg
        logic hit_base, hit_map;
        assign hit_base = we && (int'(sel[2:1]) == i) && !sel[0];
        assign hit_map  = we && (int'(sel[2:1]) == i) &&  sel[0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[i] <= '0;
                map_o[i]  <= '0;
            end else begin
                if (hit_base) begin
                    if (i == IO_IDX) base_o[i] <= {{(ADDR_W-MAP_W){1'b0}}, wdata[MAP_W-1:0]};
                    else             base_o[i] <= wdata;
                end
                if (hit_map) map_o[i] <= wdata[MAP_W-1:0];
            end
        end
    end
endmodule

// File: rtl/xlat_window.sv
module xlat_window
    import xlat_pkg::*;
#(
    parameter bit IO_ONLY = 1'b0
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [MAP_W-1:0]  map,
    input  logic [ADDR_W-1:0] addr,
    output win_result_t       res
);
    if (IO_ONLY) begin : g_io
        localparam int HB = ADDR_W - IO_LOG2;
        always_comb begin
            res.hit  = base[0] && (addr[ADDR_W-1:IO_LOG2] == base[MAP_W-1:MAP_W-HB]);
            res.addr = {map[MAP_W-1:MAP_W-HB], addr[IO_LOG2-1:0]};
            res.cyc  = CYC_IO;
            res.pf   = 1'b0;
        end
    end else begin : g_mem
        logic [3:0]        code;
        logic [5:0]        shamt;
        logic [ADDR_W-1:0] himask, map_full, xa;
        always_comb begin
            code     = base[7:4];
            shamt    = 6'(MIN_LOG2) + {2'b00, code};
            himask   = '1 << shamt;
            map_full = {map[MAP_W-1:4], {MIN_LOG2{1'b0}}};
            xa       = (map_full & himask) | (addr & ~himask);
            if (!map[0]) xa[1:0] = 2'b00;
            res.hit  = base[0] && (int'(code) <= MAX_CODE) && (((addr ^ base) & himask) == '0);
            res.addr = xa;
            res.cyc  = map[3:1];
            res.pf   = base[3];
        end
    end
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [1:0]        rsp_win,
    output logic [31:0]       rsp_addr,
    output logic [2:0]        rsp_cycle,
    output logic              rsp_prefetch
);
    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    logic [NUM_WIN-1:0][MAP_W-1:0]  map_q;
    win_result_t                    res [NUM_WIN];

    xlat_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .base_o(base_q), .map_o(map_q)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        xlat_window #(.IO_ONLY(i == NUM_WIN - 1)) u_win (
            .base(base_q[i]), .map(map_q[i]), .addr(req_addr), .res(res[i])
        );
    end

    // lowest index wins: scan downward so earlier windows overwrite later ones
    win_result_t              pick;
    logic [WIN_IDX_W-1:0]     pick_idx;
    always_comb begin
        pick     = '0;
        pick_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (res[i].hit) begin
                pick     = res[i];
                pick_idx = WIN_IDX_W'(i);
            end
        end
    end

    rsp_state_e state_q, state_d;
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) state_d = pick.hit ? ST_HIT : ST_MISS;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output data register
    logic [WIN_IDX_W-1:0] win_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [2:0]           cyc_q;
    logic                 pf_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0; addr_q <= '0; cyc_q <= '0; pf_q <= 1'b0;
        end else if (state_d == ST_HIT) begin
            win_q <= pick_idx; addr_q <= pick.addr; cyc_q <= pick.cyc; pf_q <= pick.pf;
        end else begin
            win_q <= '0; addr_q <= '0; cyc_q <= '0; pf_q <= 1'b0;
        end
    end

    always_comb begin
        rsp_hit  = 1'b0;
        rsp_miss = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT:  rsp_hit  = 1'b1;
            ST_MISS: rsp_miss = 1'b1;
            default: ;
        endcase
    end

    assign rsp_win      = 2'(win_q);
    assign rsp_addr     = addr_q;
    assign rsp_cycle    = cyc_q;
    assign rsp_prefetch = pf_q;
endmodule

// File: rtl/addr_window_xlat_chk.sv
module addr_window_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic [1:0]  rsp_win,
    input logic [31:0] rsp_addr,
    input logic [2:0]  rsp_cycle,
    input logic        rsp_prefetch
);
    assert_hit_miss_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));

    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_addr == 32'h0 && rsp_cycle == 3'b000 && !rsp_prefetch && rsp_win == 2'd0));

    assert_req_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_hit || rsp_miss));

    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_hit || rsp_miss));

    assert_io_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((rsp_hit && rsp_win == 2'd2) ->
            (rsp_cycle == 3'b001 && !rsp_prefetch && rsp_addr[23:0] == $past(req_addr[23:0]))));

    assert_win_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_win != 2'd3));
endmodule

bind addr_window_xlat addr_window_xlat_chk u_chk (.*);

// File: tb/addr_window_xlat_test.sv
module addr_window_xlat_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_hit, rsp_miss, rsp_prefetch;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_cycle;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] sh_base [3];
    logic [15:0] sh_map  [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_xlat uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
        .rsp_addr(rsp_addr), .rsp_cycle(rsp_cycle), .rsp_prefetch(rsp_prefetch)
    );

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (sel < 3'd6) begin
            if (sel[0]) sh_map[sel[2:1]] = data[15:0];
            else if (sel[2:1] == 2'd2) sh_base[2] = {16'h0, data[15:0]};
            else sh_base[sel[2:1]] = data;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic void model(input logic [31:0] a, output logic h, output logic [1:0] w,
                                  output logic [31:0] pa, output logic [2:0] cy, output logic pf);
        longint unsigned sz, aa, mp, bb, r;
        int code;
        h = 0; w = 0; pa = 0; cy = 0; pf = 0;
        aa = longint'(a);
        for (int i = 0; i < 3; i++) begin
            if (!h) begin
                if (i < 2) begin
                    code = int'(sh_base[i][7:4]);
                    if (sh_base[i][0] && code < 12) begin
                        sz = 64'd1 << (20 + code);
                        bb = longint'(sh_base[i]);
                        if (aa / sz == bb / sz) begin
                            mp = longint'(sh_map[i][15:4]) * 64'h10_0000;
                            r  = (mp / sz) * sz + aa % sz;
                            if (!sh_map[i][0]) r = (r / 4) * 4;
                            h = 1; w = 2'(i); pa = r[31:0];
                            cy = sh_map[i][3:1]; pf = sh_base[i][3];
                        end
                    end
                end else if (sh_base[2][0]) begin
                    sz = 64'd1 << 24;
                    if (aa / sz == longint'(sh_base[2][15:8])) begin
                        r = longint'(sh_map[2][15:8]) * sz + aa % sz;
                        h = 1; w = 2'd2; pa = r[31:0]; cy = 3'b001; pf = 0;
                    end
                end
            end
        end
    endfunction

    task automatic xlat(input logic [31:0] a, input string req);
        logic eh, epf;
        logic [1:0] ew;
        logic [31:0] ea;
        logic [2:0] ec;
        model(a, eh, ew, ea, ec, epf);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_hit !== eh || rsp_miss !== !eh || rsp_win !== ew || rsp_addr !== ea ||
            rsp_cycle !== ec || rsp_prefetch !== epf) begin
            errors++;
            $display("FAIL %s addr=%h: got hit=%b miss=%b win=%0d pa=%h cyc=%b pf=%b, expected hit=%b miss=%b win=%0d pa=%h cyc=%b pf=%b",
                     req, a, rsp_hit, rsp_miss, rsp_win, rsp_addr, rsp_cycle, rsp_prefetch,
                     eh, !eh, ew, ea, ec, epf);
        end
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        checks++;
        if (rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
            errors++;
            $display("FAIL %s idle: got hit=%b miss=%b, expected 0 0", req, rsp_hit, rsp_miss);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] start, sz32, b;
        for (int i = 0; i < 3; i++) begin sh_base[i] = '0; sh_map[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset, everything misses after
        checks++;
        if (rsp_hit !== 0 || rsp_miss !== 0 || rsp_addr !== 0 || rsp_cycle !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs: got hit=%b miss=%b pa=%h, expected zeros", rsp_hit, rsp_miss, rsp_addr);
        end
        rst_n = 1'b1;
        xlat(32'h0000_0000, "R1");
        xlat(32'h4000_0000, "R1");
        xlat(32'hFFFF_FFFF, "R1_R9");
        idle_check("R10");

        // R3 R4 R11: size sweep on window 0, junk in base bits below size
        for (int code = 0; code < 16; code++) begin
            b = 32'h4AB0_0000 | (code << 4) | 32'h1;
            wr(3'd0, b);
            wr(3'd1, 32'h0000_9A37);
            sz32 = (code < 12) ? (32'h1 << (20 + code)) : 32'h10_0000;
            start = b & ~(sz32 - 1);
            xlat(start, "R3_R11");
            xlat(start + sz32 - 1, "R3_R4");
            xlat(start + sz32, "R3");
            xlat(start - 1, "R3");
            xlat(start + (sz32 >> 1) + 7, "R4_R11");
        end

        // R5: low-address enable
        wr(3'd0, 32'h4000_0081);
        wr(3'd1, 32'h0000_1236);
        xlat(32'h4123_4567, "R5");
        wr(3'd1, 32'h0000_1237);
        xlat(32'h4123_4567, "R5");
        xlat(32'h4000_0002, "R5");

        // R6: cycle type and prefetch
        for (int c = 0; c < 8; c++) begin
            wr(3'd1, 32'h0000_5550 | (c << 1));
            wr(3'd0, 32'h4000_0081 | ((c & 1) << 3));
            xlat(32'h4765_4321, "R6");
        end

        // R12: disabled window
        wr(3'd0, 32'h4000_0080);
        xlat(32'h4000_1000, "R12");

        // R7: I/O window with swap bits set
        wr(3'd4, 32'hFFFF_60C1);
        wr(3'd5, 32'h0000_1200);
        xlat(32'h6000_0000, "R7");
        xlat(32'h60FF_FFFF, "R7");
        xlat(32'h6012_3457, "R7");
        xlat(32'h6100_0000, "R7");
        xlat(32'h5FFF_FFFF, "R7");
        wr(3'd4, 32'h0000_6001);
        xlat(32'h6012_3457, "R7");

        // R8: priority, window 0 grown over window 1
        wr(3'd0, 32'h4000_0091);
        wr(3'd1, 32'h0000_0006);
        wr(3'd2, 32'h5000_0089);
        wr(3'd3, 32'h0000_100C);
        xlat(32'h5000_1234, "R8");
        xlat(32'h4000_1234, "R8");
        wr(3'd0, 32'h4000_0081);
        xlat(32'h5000_1234, "R8");
        // window 1 over window 2
        wr(3'd2, 32'h6000_0041);
        wr(3'd3, 32'h0000_000B);
        xlat(32'h6000_0010, "R8");
        wr(3'd2, 32'h6000_0040);
        xlat(32'h6000_0010, "R8_R12");

        // R2: unused selects ignored; write visible to next request
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        xlat(32'h4000_1234, "R2");
        xlat(32'h6000_0010, "R2");
        xlat(32'h9000_0000, "R2");
        wr(3'd0, 32'h9000_0081);
        xlat(32'h9000_0020, "R2");
        idle_check("R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule